// File: doc/BRIEF.md
# Character device register set

This block is the register front end of a simple character I/O port, built either as an input port (a keyboard-like source delivers characters) or as an output port (a display-like sink consumes them). A CPU reaches three 16-bit words over a plain bus with a word address, a read strobe, a write strobe and write/read data. The three words are a status/control word, a data word and an interrupt vector word. One parameter selects the input or output variant at elaboration.

The status word holds the character flag, the interrupt enable and a 3-bit service priority. The character flag is driven by a two-state machine, FLAG_LOW and FLAG_HIGH. In the input variant the flag means "a character is waiting". The transition FLAG_LOW to FLAG_HIGH happens when the device strobes in a character. The transition FLAG_HIGH to FLAG_LOW happens when the CPU reads the data word. In the output variant the flag means "ready for the next character". The transition FLAG_HIGH to FLAG_LOW happens when the CPU writes the data word. The transition FLAG_LOW to FLAG_HIGH happens when the device strobes that the character was accepted.

The block raises an interrupt request while the flag and the enable are both set. Alongside the request it presents the priority from the status word and the vector number from the vector word, so that an interrupt controller can arbitrate and dispatch.

Top module: `chardev_port`

## Requirements
- R1: Word addresses are 0 = status, 1 = data, 2 = vector; address 3 reads as 0 and writes to it change nothing. The status word reads as flag in bit 15, enable in bit 14, priority in bits 2..0 and 0 in every other bit.
- R2: A status write loads the enable from bit 14 and the priority from bits 2..0. It ignores bit 15 and all other bits, so a write never changes the flag.
- R3: The vector word can be read and written in full, and it always appears on `irq_vector`.
- R4: `irq_req` is 1 exactly while the flag and the enable are both 1, and `irq_level` always equals the status priority.
- R5: Input variant: a device strobe loads `dev_char_in` into the data word (zero-extended to 16 bits) and sets the flag.
- R6: Input variant: a bus read of the data word returns the held character and clears the flag from the next cycle. If a device strobe arrives in the same cycle, the flag stays set and the new character is held.
- R7: Input variant: bus writes to the data word are ignored.
- R8: Output variant: a bus write of the data word stores its low bits, shows them on `dev_char_out` and clears the flag. `dev_pending` is 1 while the flag is 0.
- R9: Output variant: a device strobe sets the flag; a strobe while the flag is already set changes nothing. A data write in the same cycle as a strobe leaves the flag clear.
- R10: After reset the enable is 0, the data word is 0, the flag is 0 for input and 1 for output, and the priority and vector hold their parameter defaults.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Word address of the access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed word (combinational) |
| dev_strobe | input | 1 | Character delivered (input variant) or accepted (output variant) |
| dev_char_in | input | CHAR_W | Character from the device (input variant) |
| dev_char_out | output | CHAR_W | Character held in the data word |
| dev_pending | output | 1 | Input: character not yet read; output: character not yet accepted |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | 3 | Priority of the request |
| irq_vector | output | 16 | Vector table entry number |

## Verification
The bench builds two copies side by side. One is the input variant with priority default 4 and vector default 0x0180. The other is the output variant with priority default 2 and vector default 0x0190. Together they reach both state machine polarities, both same-cycle collision rules, and reset values that differ between the copies. `CHAR_W` stays at 8, so the bench can check that the upper data bits read as zero and that bits above the character width are dropped on an output write.

// File: rtl/chardev_pkg.sv
package chardev_pkg;
    localparam int WORD_W   = 16;
    localparam int PRIO_W   = 3;
    localparam int FLAG_BIT = 15;
    localparam int IE_BIT   = 14;

    typedef enum logic [1:0] {
        SEL_STAT = 2'd0,
        SEL_DATA = 2'd1,
        SEL_VECT = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic {
        FLAG_LOW  = 1'b0,
        FLAG_HIGH = 1'b1
    } flag_state_e;
endpackage

// File: rtl/chardev_flag_fsm.sv
module chardev_flag_fsm
    import chardev_pkg::*;
#(
    parameter bit IS_OUTPUT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic clr_ev,
    output logic flag
);
    localparam flag_state_e RESET_ST = IS_OUTPUT ? FLAG_HIGH : FLAG_LOW;
    // Input: a new character beats a read. Output: a new write beats an accept.
    localparam bit SET_WINS = !IS_OUTPUT;

    flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RESET_ST;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_LOW:  if (set_ev && (SET_WINS || !clr_ev)) state_d = FLAG_HIGH;
            FLAG_HIGH: if (clr_ev && (!SET_WINS || !set_ev)) state_d = FLAG_LOW;
            default:   state_d = RESET_ST;
        endcase
    end

    always_comb flag = (state_q == FLAG_HIGH);

    // R5 / R9: the flag only rises after a device strobe
    p_rise_has_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(set_ev));
    // R6 / R8: the flag only falls after the bus access that consumes it
    p_fall_has_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(clr_ev));

    generate
        if (IS_OUTPUT) begin : g_out_chk
            // R9: a fresh write in the same cycle as an accept keeps the flag low
            p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (set_ev && clr_ev) |=> !flag);
        end else begin : g_in_chk
            // R6: a fresh character in the same cycle as a read keeps the flag high
            p_char_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (set_ev && clr_ev) |=> flag);
        end
    endgenerate
endmodule

// File: rtl/chardev_regs.sv
module chardev_regs
    import chardev_pkg::*;
#(
    parameter int                 CHAR_W     = 8,
    parameter logic [PRIO_W-1:0]  PRIO_RESET = 3'd4,
    parameter logic [WORD_W-1:0]  VEC_RESET  = 16'h0180
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              vec_wr,
    input  logic              data_ld,
    input  logic [WORD_W-1:0] wdata,
    input  logic [CHAR_W-1:0] data_src,
    output logic              ie,
    output logic [PRIO_W-1:0] prio,
    output logic [WORD_W-1:0] vector,
    output logic [CHAR_W-1:0] data_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie   <= 1'b0;
            prio <= PRIO_RESET;
        end else if (ctl_wr) begin
            ie   <= wdata[IE_BIT];
            prio <= wdata[PRIO_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      vector <= VEC_RESET;
        else if (vec_wr) vector <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       data_q <= '0;
        else if (data_ld) data_q <= data_src;
    end

    // R7 / R8: the data word moves only on its own load event
    p_data_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !data_ld |=> $stable(data_q));
    // R3: the vector word moves only on a vector write
    p_vector_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_wr |=> $stable(vector));
endmodule

// File: rtl/chardev_port.sv
module chardev_port
    import chardev_pkg::*;
#(
    parameter bit           IS_OUTPUT  = 1'b0,
    parameter int           CHAR_W     = 8,
    parameter logic [2:0]   PRIO_RESET = 3'd4,
    parameter logic [15:0]  VEC_RESET  = 16'h0180
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic              dev_strobe,
    input  logic [CHAR_W-1:0] dev_char_in,
    output logic [CHAR_W-1:0] dev_char_out,
    output logic              dev_pending,
    output logic              irq_req,
    output logic [2:0]        irq_level,
    output logic [15:0]       irq_vector
);
    localparam int PAD_W  = WORD_W - CHAR_W;
    localparam int GAP_W  = IE_BIT - PRIO_W;

    reg_sel_e    sel;
    logic        wr_stat, wr_data, wr_vect, rd_data;
    logic        flag_clr, data_ld, flag, ie;
    logic [PRIO_W-1:0] prio;
    logic [WORD_W-1:0] vector;
    logic [CHAR_W-1:0] data_q, data_src;

    always_comb begin
        sel     = reg_sel_e'(bus_addr);
        wr_stat = bus_wr && (sel == SEL_STAT);
        wr_data = bus_wr && (sel == SEL_DATA);
        wr_vect = bus_wr && (sel == SEL_VECT);
        rd_data = bus_rd && (sel == SEL_DATA);
    end

    // Variant selection: who fills the data word and who consumes the flag.
    always_comb begin
        flag_clr = IS_OUTPUT ? wr_data : rd_data;
        data_ld  = IS_OUTPUT ? wr_data : dev_strobe;
        data_src = IS_OUTPUT ? bus_wdata[CHAR_W-1:0] : dev_char_in;
    end

    chardev_flag_fsm #(
        .IS_OUTPUT (IS_OUTPUT)
    ) u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_ev (dev_strobe),
        .clr_ev (flag_clr),
        .flag   (flag)
    );

    chardev_regs #(
        .CHAR_W     (CHAR_W),
        .PRIO_RESET (PRIO_RESET),
        .VEC_RESET  (VEC_RESET)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (wr_stat),
        .vec_wr   (wr_vect),
        .data_ld  (data_ld),
        .wdata    (bus_wdata),
        .data_src (data_src),
        .ie       (ie),
        .prio     (prio),
        .vector   (vector),
        .data_q   (data_q)
    );

    always_comb begin
        unique case (sel)
            SEL_STAT: bus_rdata = {flag, ie, {GAP_W{1'b0}}, prio};
            SEL_DATA: bus_rdata = {{PAD_W{1'b0}}, data_q};
            SEL_VECT: bus_rdata = vector;
            SEL_NONE: bus_rdata = '0;
            default:  bus_rdata = '0;
        endcase
    end

    always_comb begin
        irq_req      = flag && ie;
        irq_level    = prio;
        irq_vector   = vector;
        dev_char_out = data_q;
        dev_pending  = IS_OUTPUT ? !flag : flag;
    end

    // R4: clearing the enable silences the request on the next cycle
    p_ie_off_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !bus_wdata[IE_BIT]) |=> !irq_req);
    // R2: a status write sets the level seen by the interrupt controller
    p_level_loaded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat |=> (irq_level == $past(bus_wdata[PRIO_W-1:0])));
    // R2: a status write alone never moves the flag
    p_flag_untouched_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !dev_strobe) |=> $stable(bus_rdata[FLAG_BIT]) || (sel != SEL_STAT));
endmodule

// File: tb/test_chardev_port.sv
`timescale 1ns/1ps
module test_chardev_port;
    localparam int OP_IDLE = 0, OP_RD = 1, OP_WR = 2, OP_DEV = 3, OP_BOTH = 4;

    // {op[2:0], addr[1:0], data[15:0], expected read[15:0]} for the input copy
    localparam logic [36:0] TBL [13] = '{
        {3'd1, 2'd0, 16'h0000, 16'h0004},   // R10 status after reset
        {3'd2, 2'd0, 16'hC005, 16'h0000},   // R2 write with bit 15 set
        {3'd1, 2'd0, 16'h0000, 16'h4005},   // R2 flag untouched
        {3'd3, 2'd0, 16'h0041, 16'h0000},   // R5 device delivers 'A'
        {3'd1, 2'd0, 16'h0000, 16'hC005},   // R5 flag set
        {3'd1, 2'd1, 16'h0000, 16'h0041},   // R6 read character
        {3'd1, 2'd0, 16'h0000, 16'h4005},   // R6 flag cleared
        {3'd2, 2'd1, 16'h00FF, 16'h0000},   // R7 write to data
        {3'd1, 2'd1, 16'h0000, 16'h0041},   // R7 data unchanged
        {3'd1, 2'd2, 16'h0000, 16'h0180},   // R10 vector default
        {3'd2, 2'd2, 16'h1234, 16'h0000},   // R3 vector write
        {3'd1, 2'd2, 16'h0000, 16'h1234},   // R3 vector read
        {3'd1, 2'd3, 16'h0000, 16'h0000}    // R1 unused address
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [7:0]  dchar = '0;
    logic i_rd = 0, i_wr = 0, i_stb = 0, o_rd = 0, o_wr = 0, o_stb = 0;
    logic [15:0] i_rdata, o_rdata, i_vec, o_vec;
    logic [7:0]  i_cout, o_cout;
    logic        i_pend, o_pend, i_irq, o_irq;
    logic [2:0]  i_lvl, o_lvl;
    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    chardev_port #(.IS_OUTPUT(1'b0), .CHAR_W(8), .PRIO_RESET(3'd4), .VEC_RESET(16'h0180)) i_chardev_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_rd(i_rd), .bus_wr(i_wr),
        .bus_wdata(wdata), .bus_rdata(i_rdata), .dev_strobe(i_stb), .dev_char_in(dchar),
        .dev_char_out(i_cout), .dev_pending(i_pend), .irq_req(i_irq), .irq_level(i_lvl),
        .irq_vector(i_vec));

    chardev_port #(.IS_OUTPUT(1'b1), .CHAR_W(8), .PRIO_RESET(3'd2), .VEC_RESET(16'h0190)) i_chardev_port_out (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_rd(o_rd), .bus_wr(o_wr),
        .bus_wdata(wdata), .bus_rdata(o_rdata), .dev_strobe(o_stb), .dev_char_in(dchar),
        .dev_char_out(o_cout), .dev_pending(o_pend), .irq_req(o_irq), .irq_level(o_lvl),
        .irq_vector(o_vec));

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one cycle of stimulus at the falling edge; results of the previous
    // cycle are visible 1 ns later, this cycle's effect after the next rising edge.
    task automatic drive(input bit outp, input int op, input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        {i_rd, i_wr, i_stb, o_rd, o_wr, o_stb} = '0;
        addr = a; wdata = d; dchar = d[7:0];
        if (outp) begin
            o_rd  = (op == OP_RD);
            o_wr  = (op == OP_WR) || (op == OP_BOTH);
            o_stb = (op == OP_DEV) || (op == OP_BOTH);
        end else begin
            i_rd  = (op == OP_RD) || (op == OP_BOTH);
            i_wr  = (op == OP_WR);
            i_stb = (op == OP_DEV) || (op == OP_BOTH);
        end
        #1;
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10 reset state on both copies
        check("R10 in irq", {15'b0, i_irq}, 16'h0000);
        check("R10 in level", {13'b0, i_lvl}, 16'h0004);
        check("R10 in vector", i_vec, 16'h0180);
        check("R10 in pending", {15'b0, i_pend}, 16'h0000);
        check("R10 out vector", o_vec, 16'h0190);
        check("R10 out pending", {15'b0, o_pend}, 16'h0000);
        drive(1, OP_RD, 2'd0, 16'h0);
        check("R10 out status ready", o_rdata, 16'h8002);
        drive(1, OP_RD, 2'd1, 16'h0);
        check("R10 out data zero", o_rdata, 16'h0000);

        for (int i = 0; i < 13; i++) begin
            drive(0, int'(TBL[i][36:34]), TBL[i][33:32], TBL[i][31:16]);
            if (int'(TBL[i][36:34]) == OP_RD)
                check($sformatf("R1/R2/R3/R5/R6/R7 table row %0d", i), i_rdata, TBL[i][15:0]);
        end

        // Input copy: request and qualification (R4)
        drive(0, OP_DEV, 2'd0, 16'h0042);
        drive(0, OP_IDLE, 2'd0, 16'h0);
        check("R4 in irq set", {15'b0, i_irq}, 16'h0001);
        check("R4 in level", {13'b0, i_lvl}, 16'h0005);
        check("R3 vector on port", i_vec, 16'h1234);
        check("R5 pending", {15'b0, i_pend}, 16'h0001);
        drive(0, OP_WR, 2'd0, 16'h0005);
        drive(0, OP_RD, 2'd0, 16'h0);
        check("R4 irq off with enable 0", {15'b0, i_irq}, 16'h0000);
        check("R4 flag kept", i_rdata, 16'h8005);
        // R6: read and delivery in the same cycle
        drive(0, OP_BOTH, 2'd1, 16'h0043);
        check("R6 read returns old char", i_rdata, 16'h0042);
        drive(0, OP_RD, 2'd0, 16'h0);
        check("R6 flag stays set", i_rdata, 16'h8005);
        drive(0, OP_RD, 2'd1, 16'h0);
        check("R6 new char held", i_rdata, 16'h0043);
        drive(0, OP_RD, 2'd0, 16'h0);
        check("R6 flag cleared after read", i_rdata, 16'h0005);

        // Output copy
        drive(1, OP_WR, 2'd0, 16'h4003);
        drive(1, OP_IDLE, 2'd0, 16'h0);
        check("R4 out irq while ready", {15'b0, o_irq}, 16'h0001);
        check("R4 out level", {13'b0, o_lvl}, 16'h0003);
        drive(1, OP_WR, 2'd1, 16'h0158);
        drive(1, OP_RD, 2'd0, 16'h0);
        check("R8 ready cleared", o_rdata, 16'h4003);
        check("R8 char shown", {8'b0, o_cout}, 16'h0058);
        check("R8 pending", {15'b0, o_pend}, 16'h0001);
        check("R4 out irq dropped", {15'b0, o_irq}, 16'h0000);
        drive(1, OP_DEV, 2'd0, 16'h0);
        drive(1, OP_RD, 2'd0, 16'h0);
        check("R9 ready after accept", o_rdata, 16'hC003);
        check("R9 pending cleared", {15'b0, o_pend}, 16'h0000);
        drive(1, OP_DEV, 2'd0, 16'h0);
        drive(1, OP_RD, 2'd1, 16'h0);
        check("R9 stray accept keeps data", o_rdata, 16'h0058);
        drive(1, OP_RD, 2'd0, 16'h0);
        check("R9 stray accept keeps status", o_rdata, 16'hC003);
        drive(1, OP_BOTH, 2'd1, 16'h0021);
        drive(1, OP_RD, 2'd0, 16'h0);
        check("R9 write beats accept", o_rdata, 16'h4003);
        check("R8 new char shown", {8'b0, o_cout}, 16'h0021);
        drive(1, OP_RD, 2'd3, 16'h0);
        check("R1 out unused address", o_rdata, 16'h0000);
        drive(1, OP_IDLE, 2'd0, 16'h0);

        finish_run();
    end
endmodule